// File: doc/BRIEF.md
# SD Bus Power and Card-Detect Controller

This block holds the bus-voltage code and the bus-power enable of an SD host, and it decides whether a card is present. Software writes a 3-bit voltage code, a power bit, a detect-source select and a test level. Each field has its own write strobe. The block also samples three capability inputs, one for each supply level it can offer, and an external card-detect pin that is active low.

A power-on write takes effect only when the voltage code already held names a level that the capability inputs support. Power falls by itself as soon as no card is seen. The card-present state normally comes from the pin, through a two-flop synchronizer. A select bit can instead take it from a software test level, which is useful for bring-up. A command-register write strobe passes through to a start output only while bus power is on.

Top module: `sd_pwr_detect_ctrl`

## Requirements
- R1: After reset, bus power and the voltage code are 0. The detect source is the pin, the test level is 0, and card_present is 0.
- R2: A voltage write stores its 3-bit value in bus_vsel on the next clock edge. A voltage write alone never changes bus_pwr_en.
- R3: A power write of 1 sets bus_pwr_en only if a card is present and the code held before that edge is supported. Code 5 needs cap_v18, code 6 needs cap_v30 and code 7 needs cap_v33. A voltage write in the same cycle does not count.
- R4: Voltage codes 0 to 4 are never supported, whatever the capability inputs are.
- R5: A power write of 0 clears bus_pwr_en on the next edge.
- R6: While card_present is 0, bus_pwr_en is 0 after the next edge. This takes priority over a power write of 1.
- R7: cmd_start equals cmd_wr while bus_pwr_en is 1, and it is 0 while bus_pwr_en is 0.
- R8: With detect select 0, card_present is the inverse of card_det_n after two flops. A pin change shows up after the second rising edge and not after the first.
- R9: With detect select 1, card_present equals the stored test level (1 = card inserted). It follows the test level on the edge after the write.
- R10: The synchronizer resets to the pin-high value, so no card is reported until the pin has been low for two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsel_wr | input | 1 | Write strobe for the voltage code |
| vsel_wdata | input | 3 | Voltage code to write |
| pwr_wr | input | 1 | Write strobe for the power bit |
| pwr_wdata | input | 1 | Power bit to write |
| cdsel_wr | input | 1 | Write strobe for the detect-source select |
| cdsel_wdata | input | 1 | Detect source: 0 = pin, 1 = test level |
| tlvl_wr | input | 1 | Write strobe for the test level |
| tlvl_wdata | input | 1 | Test level: 1 = card inserted |
| cap_v18 | input | 1 | 1.8 V supply supported |
| cap_v30 | input | 1 | 3.0 V supply supported |
| cap_v33 | input | 1 | 3.3 V supply supported |
| card_det_n | input | 1 | External card-detect pin, active low |
| cmd_wr | input | 1 | Command-register write strobe |
| bus_pwr_en | output | 1 | Bus power enable |
| bus_vsel | output | 3 | Stored voltage code |
| card_present | output | 1 | Card-present state |
| cmd_start | output | 1 | Command write allowed to start a transfer |

## Verification
The hardest case to reach is a power-on write that arrives together with a voltage write. The outcome must depend on the old code, not on the one being written. A directed step sets up a supported code and then writes an unsupported code and power-on in the same cycle. Random cycles also produce this collision, together with caps that change and losses of card presence that overrule the write. A second hard case is the pin delay. A directed step drops the pin and looks after one edge, when no card should be shown yet, and again after two edges.

// File: rtl/sdpd_pkg.sv
package sdpd_pkg;

    parameter int VSEL_W = 3;

    typedef logic [VSEL_W-1:0] vcode_t;

    localparam vcode_t VCODE_1V8 = vcode_t'(5);
    localparam vcode_t VCODE_3V0 = vcode_t'(6);
    localparam vcode_t VCODE_3V3 = vcode_t'(7);

    typedef struct packed {
        vcode_t vsel;
        logic   pwr;
    } pwr_state_t;

    typedef struct packed {
        logic src_test;
        logic test_lvl;
    } det_state_t;

    // Returns 1 when the code names a level whose capability input is set.
    function automatic logic vcode_ok(vcode_t code, logic c18, logic c30, logic c33);
        logic ok;
        case (code)
            VCODE_1V8: ok = c18;
            VCODE_3V0: ok = c30;
            VCODE_3V3: ok = c33;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sdpd_sync.sv
module sdpd_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        stage_d[0] = din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_chain
            always_comb begin
                stage_d[i] = stage_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sdpd_detect.sv
module sdpd_detect
    import sdpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cdsel_wr,
    input  logic cdsel_wdata,
    input  logic tlvl_wr,
    input  logic tlvl_wdata,
    input  logic pin_n_sync,
    output logic card_present
);
    det_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cdsel_wr) begin
            st_d.src_test = cdsel_wdata;
        end
        if (tlvl_wr) begin
            st_d.test_lvl = tlvl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.src_test) begin
            card_present = st_q.test_lvl;
        end else begin
            card_present = ~pin_n_sync;
        end
    end

    // R9: a test level of 1 selected in the previous cycle reports a card
    a_r9_test_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cdsel_wr && cdsel_wdata && tlvl_wr && tlvl_wdata) |=> card_present);

endmodule

// File: rtl/sdpd_power.sv
module sdpd_power
    import sdpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   vsel_wr,
    input  vcode_t vsel_wdata,
    input  logic   pwr_wr,
    input  logic   pwr_wdata,
    input  logic   cap_v18,
    input  logic   cap_v30,
    input  logic   cap_v33,
    input  logic   card_present,
    output logic   pwr_on,
    output vcode_t vsel
);
    pwr_state_t st_d, st_q;
    logic       code_ok;

    always_comb begin
        code_ok = vcode_ok(st_q.vsel, cap_v18, cap_v30, cap_v33);
        st_d    = st_q;
        if (vsel_wr) begin
            st_d.vsel = vsel_wdata;
        end
        if (!card_present) begin
            st_d.pwr = 1'b0;
        end else if (pwr_wr) begin
            if (!pwr_wdata) begin
                st_d.pwr = 1'b0;
            end else if (code_ok) begin
                st_d.pwr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_on = st_q.pwr;
    assign vsel   = st_q.vsel;

    // R2: the code changes only on a voltage write
    a_r2_vsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vsel_wr |=> $stable(st_q.vsel));

    // R3: power rises only after an accepted power-on write
    a_r3_rise_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pwr) |-> $past(pwr_wr && pwr_wdata && card_present
                                  && vcode_ok(st_q.vsel, cap_v18, cap_v30, cap_v33)));

    // R6: the loss of a card drops power on the next edge
    a_r6_no_card_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !card_present |=> !st_q.pwr);

endmodule

// File: rtl/sd_pwr_detect_ctrl.sv
module sd_pwr_detect_ctrl
    import sdpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsel_wr,
    input  logic [VSEL_W-1:0] vsel_wdata,
    input  logic              pwr_wr,
    input  logic              pwr_wdata,
    input  logic              cdsel_wr,
    input  logic              cdsel_wdata,
    input  logic              tlvl_wr,
    input  logic              tlvl_wdata,
    input  logic              cap_v18,
    input  logic              cap_v30,
    input  logic              cap_v33,
    input  logic              card_det_n,
    input  logic              cmd_wr,
    output logic              bus_pwr_en,
    output logic [VSEL_W-1:0] bus_vsel,
    output logic              card_present,
    output logic              cmd_start
);
    logic pin_n_sync;
    logic present;
    logic pwr_on;

    sdpd_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (card_det_n),
        .dout  (pin_n_sync)
    );

    sdpd_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .cdsel_wr     (cdsel_wr),
        .cdsel_wdata  (cdsel_wdata),
        .tlvl_wr      (tlvl_wr),
        .tlvl_wdata   (tlvl_wdata),
        .pin_n_sync   (pin_n_sync),
        .card_present (present)
    );

    sdpd_power u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsel_wr      (vsel_wr),
        .vsel_wdata   (vsel_wdata),
        .pwr_wr       (pwr_wr),
        .pwr_wdata    (pwr_wdata),
        .cap_v18      (cap_v18),
        .cap_v30      (cap_v30),
        .cap_v33      (cap_v33),
        .card_present (present),
        .pwr_on       (pwr_on),
        .vsel         (bus_vsel)
    );

    assign bus_pwr_en   = pwr_on;
    assign card_present = present;
    assign cmd_start    = cmd_wr & pwr_on;

    // R7: no transfer can start in the cycle after a card was missing
    a_r7_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> !cmd_start);

endmodule

// File: tb/sd_pwr_detect_ctrl_test.sv
module sd_pwr_detect_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsel_wr = 0, pwr_wr = 0, pwr_wdata = 0;
    logic [2:0] vsel_wdata = 0;
    logic       cdsel_wr = 0, cdsel_wdata = 0, tlvl_wr = 0, tlvl_wdata = 0;
    logic       cap_v18 = 0, cap_v30 = 0, cap_v33 = 0;
    logic       card_det_n = 1, cmd_wr = 0;
    logic       bus_pwr_en, card_present, cmd_start;
    logic [2:0] bus_vsel;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [2:0] m_vsel;
    logic       m_pwr, m_src, m_tl, m_s1, m_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_pwr_detect_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .vsel_wr(vsel_wr), .vsel_wdata(vsel_wdata),
        .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
        .cdsel_wr(cdsel_wr), .cdsel_wdata(cdsel_wdata),
        .tlvl_wr(tlvl_wr), .tlvl_wdata(tlvl_wdata),
        .cap_v18(cap_v18), .cap_v30(cap_v30), .cap_v33(cap_v33),
        .card_det_n(card_det_n), .cmd_wr(cmd_wr),
        .bus_pwr_en(bus_pwr_en), .bus_vsel(bus_vsel),
        .card_present(card_present), .cmd_start(cmd_start)
    );

    function automatic logic supported(logic [2:0] c, logic a, logic b, logic d);
        if (c == 3'd5) return a;
        if (c == 3'd6) return b;
        if (c == 3'd7) return d;
        return 1'b0;
    endfunction

    function automatic logic model_present();
        return m_src ? m_tl : ~m_s2;
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_vsel = 0; m_pwr = 0; m_src = 0; m_tl = 0; m_s1 = 1; m_s2 = 1;
    endtask

    task automatic model_edge();
        logic cp;
        cp = model_present();
        if (!cp) m_pwr = 0;
        else if (pwr_wr) begin
            if (!pwr_wdata) m_pwr = 0;
            else if (supported(m_vsel, cap_v18, cap_v30, cap_v33)) m_pwr = 1;
        end
        if (vsel_wr)  m_vsel = vsel_wdata;
        if (cdsel_wr) m_src = cdsel_wdata;
        if (tlvl_wr)  m_tl = tlvl_wdata;
        m_s2 = m_s1;
        m_s1 = card_det_n;
    endtask

    // Inputs are already driven after a negedge; check comb, clock, check regs.
    task automatic cycle();
        #1;
        check("R7 cmd_start", {2'b0, cmd_start}, {2'b0, cmd_wr & m_pwr});
        @(posedge clk);
        model_edge();
        #1;
        check("R3 bus_pwr_en", {2'b0, bus_pwr_en}, {2'b0, m_pwr});
        check("R2 bus_vsel", bus_vsel, m_vsel);
        check(m_src ? "R9 card_present" : "R8 card_present",
              {2'b0, card_present}, {2'b0, model_present()});
        @(negedge clk);
        vsel_wr = 0; pwr_wr = 0; cdsel_wr = 0; tlvl_wr = 0; cmd_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        check("R1 pwr reset", {2'b0, bus_pwr_en}, 3'd0);
        check("R1 vsel reset", bus_vsel, 3'd0);
        check("R10 no card at reset", {2'b0, card_present}, 3'd0);
        @(negedge clk);
        rst_n = 1;

        // R9 test level selected
        cdsel_wr = 1; cdsel_wdata = 1; tlvl_wr = 1; tlvl_wdata = 1;
        cap_v18 = 1;
        vsel_wr = 1; vsel_wdata = 3'd5;
        cycle();
        check("R9 test level present", {2'b0, card_present}, 3'd1);
        // R3 supported 1.8 V power-on
        pwr_wr = 1; pwr_wdata = 1; cycle();
        check("R3 accepted", {2'b0, bus_pwr_en}, 3'd1);
        cmd_wr = 1; #1;
        check("R7 start while on", {2'b0, cmd_start}, 3'd1);
        cycle();
        // R5 power off
        pwr_wr = 1; pwr_wdata = 0; cycle();
        check("R5 power off", {2'b0, bus_pwr_en}, 3'd0);
        // R3 unsupported 3.0 V
        vsel_wr = 1; vsel_wdata = 3'd6; cycle();
        pwr_wr = 1; pwr_wdata = 1; cycle();
        check("R3 rejected no cap", {2'b0, bus_pwr_en}, 3'd0);
        cmd_wr = 1; #1;
        check("R7 blocked while off", {2'b0, cmd_start}, 3'd0);
        cycle();
        // R4 unsupported code with all caps
        cap_v18 = 1; cap_v30 = 1; cap_v33 = 1;
        vsel_wr = 1; vsel_wdata = 3'd2; cycle();
        pwr_wr = 1; pwr_wdata = 1; cycle();
        check("R4 code 2 rejected", {2'b0, bus_pwr_en}, 3'd0);
        // R3 old code counts: hold 7, then write 2 together with power-on
        vsel_wr = 1; vsel_wdata = 3'd7; cycle();
        vsel_wr = 1; vsel_wdata = 3'd2; pwr_wr = 1; pwr_wdata = 1; cycle();
        check("R3 old code used", {2'b0, bus_pwr_en}, 3'd1);
        check("R2 new code stored", bus_vsel, 3'd2);
        // R6 card removed, power-on write loses
        tlvl_wr = 1; tlvl_wdata = 0; cycle();
        pwr_wr = 1; pwr_wdata = 1; cycle();
        check("R6 dropped on no card", {2'b0, bus_pwr_en}, 3'd0);
        // R8 pin path, two-edge latency
        cdsel_wr = 1; cdsel_wdata = 0; cycle();
        card_det_n = 0; cycle();
        check("R8 not yet after one edge", {2'b0, card_present}, 3'd0);
        cycle();
        check("R8 present after two edges", {2'b0, card_present}, 3'd1);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 31) == 0) begin
                cap_v18 = 1'($urandom); cap_v30 = 1'($urandom); cap_v33 = 1'($urandom);
            end
            if ($urandom_range(0, 7) == 0) card_det_n = ~card_det_n;
            if ($urandom_range(0, 3) == 0) begin
                vsel_wr = 1; vsel_wdata = 3'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 2) == 0) begin
                pwr_wr = 1; pwr_wdata = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 40) == 0) begin
                cdsel_wr = 1; cdsel_wdata = 1'($urandom);
            end
            if ($urandom_range(0, 10) == 0) begin
                tlvl_wr = 1; tlvl_wdata = 1'($urandom);
            end
            cmd_wr = 1'($urandom);
            cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule